// File: doc/BRIEF.md
# Subcode Block Sync Tracker

This block follows the subcode stream of an optical-disc channel decoder and finds where each subcode block starts. Once per channel frame it receives the 14-bit subcode symbol that leads the frame, marked by a one-cycle frame strobe. A block is recognised when one frame carries the first reserved sync symbol and the next frame carries the second. The block then emits a one-cycle sub-sync pulse and starts a symbol index at zero.

A subcode block always holds 98 symbols. A modulo-98 flywheel counter therefore keeps the pulse going at the fixed block length when a sync symbol is damaged or missing. A sync pair that turns up at a phase different from the flywheel is treated as suspect. It is adopted only if it appears again exactly one block later. Downstream logic uses the pulse and the index to place each subcode byte inside its block.

The symbol that completes the sync pair (the second sync symbol) receives index 0. The first sync symbol therefore sits at index 97 of the preceding block.

Top module: `subcode_block_sync`

## Requirements
- R1: While reset is asserted, and after it is released, `sub_sync` is 0 and `sym_idx` is 0. The tracker starts unlocked.
- R2: The first sync symbol is 14'b00100000000001 and the second is 14'b00000000010010, and both are compared on all bits. Suppose the first sync symbol arrives on one strobe and the second on the next strobe, with any number of non-strobe cycles between them. In the unlocked state, the cycle after the second strobe shows `sub_sync`=1 and `sym_idx`=0, and the tracker becomes locked.
- R3: While unlocked, no other input sequence produces a pulse or moves `sym_idx` from 0. This covers the reversed order, a lone first sync symbol, and a first sync symbol followed by an unrelated symbol.
- R4: While locked, `sym_idx` rises by exactly 1 in the cycle after each strobe and holds its value in every cycle that follows no strobe.
- R5: While locked, the strobe that arrives when `sym_idx` is 97 returns `sym_idx` to 0 and produces a pulse, even if no sync pair is present (interpolation).
- R6: A sync pair whose second symbol arrives when `sym_idx` is 97 gives exactly one pulse and `sym_idx`=0.
- R7: While locked, a single sync pair that completes at any other index is ignored. `sym_idx` keeps counting and no pulse occurs.
- R8: A misplaced pair that is completed again exactly 98 strobes after the previous one is accepted. The cycle after its second symbol shows `sub_sync`=1 and `sym_idx`=0.
- R9: `sub_sync` is high for exactly one cycle, and only in the cycle following a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_stb | input | 1 | One-cycle marker that a new frame's subcode symbol is on `sub_sym` |
| sub_sym | input | 14 | Subcode symbol of the current frame |
| sub_sync | output | 1 | One-cycle pulse marking the start of a subcode block |
| sym_idx | output | 7 | Index of the last received symbol within its block, 0 to 97 |

## Verification
Before lock, the pair detector is driven with the reversed sync order, with a lone first sync symbol, and with a first sync symbol followed by a foreign symbol. These cases separate a true ordered-pair match from a check of either symbol on its own. After lock, long runs of plain symbols with no sync show that the flywheel alone produces the pulse at index 97. A pair placed exactly on the flywheel phase shows that a real sync and an interpolated one do not stack into a second pulse. A single pair placed off phase, followed by the same pair one block later, separates rejection of a stray sync from adoption of a genuine phase change. A reset in the middle of a run confirms that the lock is dropped.

// File: rtl/subsync_pkg.sv
package subsync_pkg;
  localparam int unsigned SYM_W_DEF     = 14;
  localparam int unsigned BLOCK_LEN_DEF = 98;
  localparam logic [SYM_W_DEF-1:0] SYNC_A_DEF = 14'b00100000000001;
  localparam logic [SYM_W_DEF-1:0] SYNC_B_DEF = 14'b00000000010010;
endpackage

// File: rtl/subsync_rst_sync.sv
module subsync_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/subsync_pair_detect.sv
module subsync_pair_detect #(
  parameter int unsigned     SYM_W  = 14,
  parameter logic [SYM_W-1:0] SYNC_A = '0,
  parameter logic [SYM_W-1:0] SYNC_B = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [SYM_W-1:0] sym,
  output logic             pair_hit
);
  logic prev_a_q, prev_a_d;
  logic is_a, is_b;

  assign is_a = (sym == SYNC_A);
  assign is_b = (sym == SYNC_B);

  always_comb begin
    prev_a_d = prev_a_q;
    if (stb) prev_a_d = is_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_a_q <= 1'b0;
    else        prev_a_q <= prev_a_d;
  end

  assign pair_hit = stb & prev_a_q & is_b;
endmodule

// File: rtl/subsync_modcnt.sv
module subsync_modcnt #(
  parameter int unsigned N = 98,
  parameter int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(N - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/subcode_block_sync.sv
module subcode_block_sync
  import subsync_pkg::*;
#(
  parameter int unsigned      SYM_W     = SYM_W_DEF,
  parameter int unsigned      BLOCK_LEN = BLOCK_LEN_DEF,
  parameter logic [SYM_W-1:0] SYNC_A    = SYNC_A_DEF,
  parameter logic [SYM_W-1:0] SYNC_B    = SYNC_B_DEF,
  localparam int unsigned     IDX_W     = $clog2(BLOCK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [SYM_W-1:0] sub_sym,
  output logic             sub_sync,
  output logic [IDX_W-1:0] sym_idx
);
  logic rst_i_n;
  logic pair_hit;
  logic main_last, cand_last;
  logic [IDX_W-1:0] cand_cnt;

  logic locked_q, locked_d;
  logic cand_q, cand_d;
  logic pulse_q, pulse_d;

  logic in_phase, off_phase, confirm, load_zero, cand_start;

  subsync_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  subsync_pair_detect #(.SYM_W(SYM_W), .SYNC_A(SYNC_A), .SYNC_B(SYNC_B)) det_i (
    .clk(clk), .rst_n(rst_i_n), .stb(frame_stb), .sym(sub_sym), .pair_hit(pair_hit)
  );

  // block flywheel
  subsync_modcnt #(.N(BLOCK_LEN), .W(IDX_W)) main_cnt_i (
    .clk(clk), .rst_n(rst_i_n), .en(frame_stb & locked_q), .clr(load_zero),
    .cnt(sym_idx), .last(main_last)
  );

  // distance since the last off-phase pair
  subsync_modcnt #(.N(BLOCK_LEN), .W(IDX_W)) cand_cnt_i (
    .clk(clk), .rst_n(rst_i_n), .en(frame_stb & cand_q), .clr(cand_start),
    .cnt(cand_cnt), .last(cand_last)
  );

  always_comb begin
    in_phase   = locked_q & pair_hit & main_last;
    off_phase  = locked_q & pair_hit & ~main_last;
    confirm    = off_phase & cand_q & cand_last;
    load_zero  = (~locked_q & pair_hit) | confirm;
    cand_start = off_phase & ~confirm;

    locked_d = locked_q | pair_hit;
    pulse_d  = (frame_stb & locked_q & main_last) | load_zero;

    cand_d = cand_q;
    if (frame_stb) begin
      if (confirm | in_phase)      cand_d = 1'b0;
      else if (off_phase)          cand_d = 1'b1;
      else if (cand_q & cand_last) cand_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      locked_q <= 1'b0;
      cand_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      locked_q <= locked_d;
      cand_q   <= cand_d;
      pulse_q  <= pulse_d;
    end
  end

  assign sub_sync = pulse_q;
endmodule

// File: rtl/subsync_chk.sv
module subsync_chk #(
  parameter int unsigned BLOCK_LEN = 98,
  parameter int unsigned IDX_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic             sub_sync,
  input logic [IDX_W-1:0] sym_idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(BLOCK_LEN - 1);

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_idx <= TOP);

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> $stable(sym_idx));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_stb) && $past(sym_idx) != '0 && $past(sym_idx) != TOP && !sub_sync)
      |-> sym_idx == $past(sym_idx) + IDX_W'(1));

  // R5
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_stb) && $past(sym_idx) == TOP) |-> (sub_sync && sym_idx == '0));

  // R9
  pulse_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_sync |-> $past(frame_stb));

  // R6
  pulse_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_sync |-> sym_idx == '0);
endmodule

bind subcode_block_sync subsync_chk #(.BLOCK_LEN(BLOCK_LEN), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sub_sync(sub_sync), .sym_idx(sym_idx)
);

// File: tb/subcode_block_sync_tb_top.sv
module subcode_block_sync_tb_top;
  localparam logic [13:0] SA = 14'b00100000000001;
  localparam logic [13:0] SB = 14'b00000000010010;
  localparam logic [13:0] SX = 14'h1555;
  localparam int NV = 12;
  // {expected pulse, expected index, symbol}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 7'd0, SX},  // R3 plain symbol
    {1'b0, 7'd0, SB},  // R3 second sync alone
    {1'b0, 7'd0, SA},  // R3 reversed order: no pair
    {1'b0, 7'd0, SX},  // R3 first sync then foreign
    {1'b0, 7'd0, SB},
    {1'b0, 7'd0, SA},
    {1'b1, 7'd0, SB},  // R2 lock
    {1'b0, 7'd1, SX},  // R4
    {1'b0, 7'd2, SX},
    {1'b0, 7'd3, SA},
    {1'b0, 7'd4, SB},  // R7 off-phase pair ignored
    {1'b0, 7'd5, SX}
  };

  logic clk, rst_n, frame_stb;
  logic [13:0] sub_sym;
  logic sub_sync;
  logic [6:0] sym_idx;
  int n_chk, n_bad;
  int e_idx;

  subcode_block_sync dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sub_sym(sub_sym),
    .sub_sync(sub_sync), .sym_idx(sym_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic es, input int ei);
    n_chk++;
    if (sub_sync !== es || int'(sym_idx) != ei) begin
      n_bad++;
      $display("FAIL %s: got sync=%0b idx=%0d, expected sync=%0b idx=%0d",
               req, sub_sync, sym_idx, es, ei);
    end
  endtask

  task automatic strobe(input logic [13:0] s);
    @(negedge clk);
    frame_stb = 1'b1;
    sub_sym   = s;
    @(negedge clk);
    frame_stb = 1'b0;
    sub_sym   = SX;
  endtask

  task automatic step(input logic [13:0] s, input logic es, input int ei, input string req);
    strobe(s);
    check(req, es, ei);
    e_idx = ei;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; e_idx = 0;
    frame_stb = 1'b0; sub_sym = SX;
    do_reset();
    check("R1 reset state", 1'b0, 0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][13:0], VEC[i][21], int'(VEC[i][20:14]), "R2/R3/R4/R7 table");

    // R9 / R4 hold in the gap cycle
    @(negedge clk);
    check("R9 R4 no strobe hold", 1'b0, e_idx);

    // R5 interpolated wrap
    while (e_idx < 97) step(SX, 1'b0, e_idx + 1, "R4 count");
    step(SX, 1'b1, 0, "R5 interpolated pulse");
    @(negedge clk);
    check("R9 pulse one cycle", 1'b0, 0);

    // R6 in-phase pair at the wrap
    while (e_idx < 96) step(SX, 1'b0, e_idx + 1, "R4 count");
    step(SA, 1'b0, 97, "R6 first sync at 97");
    step(SB, 1'b1, 0, "R6 in-phase pair");
    @(negedge clk);
    check("R6 single pulse", 1'b0, 0);

    // R8 off-phase pair confirmed one block later
    while (e_idx < 8) step(SX, 1'b0, e_idx + 1, "R4 count");
    step(SA, 1'b0, 9, "R8 setup");
    step(SB, 1'b0, 10, "R7 first off-phase pair");
    for (int j = 1; j <= 96; j++) begin
      if (e_idx == 97) step(SX, 1'b1, 0, "R5 interpolated pulse");
      else             step(SX, 1'b0, e_idx + 1, "R4 count");
    end
    step(SA, 1'b0, 9, "R8 first sync");
    step(SB, 1'b1, 0, "R8 confirmed new phase");
    step(SX, 1'b0, 1, "R8 count from new phase");

    // R1 reset drops lock
    do_reset();
    check("R1 reset mid-run", 1'b0, 0);
    step(SX, 1'b0, 0, "R1 R3 unlocked after reset");
    step(SA, 1'b0, 0, "R3 lone first sync");
    step(SA, 1'b0, 0, "R3 repeated first sync");
    step(SB, 1'b1, 0, "R2 relock");
    step(SX, 1'b0, 1, "R4 count after relock");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule